// File: doc/BRIEF.md
# Serial Transmitter with Source Fetch

This block serialises bytes onto one asynchronous transmit line. It does not receive bytes pushed to it. It pulls each byte from an upstream queue. When the queue reports that it holds data and the transmitter is idle, the block raises a read request for a single clock. The queue answers one cycle later by presenting the byte on the data bus. The block captures that byte and starts shifting it out on the next cycle.

Each character on the line is made of eleven bit periods:

- a low start bit;
- the eight data bits, least significant first;
- an even-parity bit;
- a high stop bit.

Every bit period lasts a parameterised number of clock cycles. The line rests high whenever no character is in flight. If the queue still holds data when a stop bit ends, the next request follows at once, so characters can run back to back. The synchronous reset drops any character in progress and returns the line to its high rest level.

Top module: `uart_fetch_tx`

## Requirements
- R1: `src_rd` is never high in two consecutive cycles. It is raised only when `src_empty` was low in the preceding cycle.
- R2: The data bus is captured in the cycle after `src_rd` is high. `tx_line` stays high during the strobe cycle and the capture cycle. `tx_line` goes low (start bit) in the cycle right after the capture cycle.
- R3: After the start bit, `tx_line` carries the captured byte starting with bit 0 and ending with bit 7. Then it carries the parity bit. Then it carries a stop bit of value 1.
- R4: Each of the eleven bit values is held on `tx_line` for exactly BIT_TICKS consecutive clock cycles (default 5).
- R5: The parity bit equals the XOR of the eight captured data bits, which gives even parity.
- R6: `tx_line` is 1 whenever no character is being sent, including during reset and right after it.
- R7: With `rst` high at a clock edge, the next cycle has `tx_line` = 1 and `src_rd` = 0, even in the middle of a character.
- R8: `src_rd` stays low from the capture cycle through the last cycle of the stop bit.
- R9: If `src_empty` is low in the last cycle of a stop bit, `src_rd` is high in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_data | input | DATA_W | Byte from the upstream queue, valid the cycle after `src_rd` |
| src_empty | input | 1 | High when the upstream queue holds no data |
| src_rd | output | 1 | One-cycle read request to the upstream queue |
| tx_line | output | 1 | Serial transmit line, high at rest |

## Verification
The hardest case to reach is the hand-off at the end of a stop bit. There the queue must hold data in exactly the last stop cycle, so that a new request follows with no idle gap. The stimulus reaches this by loading bursts of several bytes at once, which keeps the queue non-empty across many frame boundaries. Random idle gaps between bursts also exercise the ordinary path from idle. A second hard case is a reset that lands deep inside a character. A directed sequence waits for a request, lets the frame run for twenty cycles, and only then pulses reset.

// File: rtl/uftx_pkg.sv
package uftx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_CAPT,
        ST_SEND
    } tx_state_e;
endpackage

// File: rtl/uftx_frame_pack.sv
// Builds the full character, LSB first: start(0), data, even parity, stop(1).
module uftx_frame_pack #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] byte_i,
    output logic [DATA_W+2:0] frame_o
);
    logic par;

    always_comb begin
        par = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            par = par ^ byte_i[i];
        end
        frame_o = {1'b1, par, byte_i, 1'b0};
    end
endmodule

// File: rtl/uftx_bit_timer.sv
// Counts the clocks of one bit period; restart aligns the period to a new frame.
module uftx_bit_timer #(
    parameter int BIT_TICKS = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic bit_end
);
    localparam int CW = (BIT_TICKS > 1) ? $clog2(BIT_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(BIT_TICKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign bit_end = (cnt_q == LAST);

    always_comb begin
        if (restart || bit_end) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/uart_fetch_tx.sv
module uart_fetch_tx #(
    parameter int BIT_TICKS = 5,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_empty,
    output logic              src_rd,
    output logic              tx_line
);
    import uftx_pkg::*;

    localparam int FRAME_W = DATA_W + 3;
    localparam int IDX_W   = $clog2(FRAME_W);

    typedef struct packed {
        tx_state_e          st;
        logic               rd;
        logic               tx;
        logic [FRAME_W-1:0] sh;
        logic [IDX_W-1:0]   left;
    } regs_t;

    regs_t r_d, r_q;
    logic [FRAME_W-1:0] frame_w;
    logic bit_end;
    logic tmr_restart;

    uftx_frame_pack #(.DATA_W(DATA_W)) u_pack (
        .byte_i (src_data),
        .frame_o(frame_w)
    );

    uftx_bit_timer #(.BIT_TICKS(BIT_TICKS)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .restart(tmr_restart),
        .bit_end(bit_end)
    );

    always_comb begin
        r_d         = r_q;
        r_d.rd      = 1'b0;
        tmr_restart = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                r_d.tx = 1'b1;
                if (!src_empty) begin
                    r_d.rd = 1'b1;
                    r_d.st = ST_REQ;
                end
            end
            ST_REQ: begin
                // source drives the byte during the next cycle
                r_d.st = ST_CAPT;
            end
            ST_CAPT: begin
                r_d.tx      = frame_w[0];
                r_d.sh      = {1'b1, frame_w[FRAME_W-1:1]};
                r_d.left    = IDX_W'(FRAME_W - 1);
                tmr_restart = 1'b1;
                r_d.st      = ST_SEND;
            end
            ST_SEND: begin
                if (bit_end) begin
                    if (r_q.left == '0) begin
                        r_d.tx = 1'b1;
                        if (!src_empty) begin
                            r_d.rd = 1'b1;
                            r_d.st = ST_REQ;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end else begin
                        r_d.tx   = r_q.sh[0];
                        r_d.sh   = {1'b1, r_q.sh[FRAME_W-1:1]};
                        r_d.left = r_q.left - 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st   <= ST_IDLE;
            r_q.rd   <= 1'b0;
            r_q.tx   <= 1'b1;
            r_q.sh   <= '1;
            r_q.left <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign src_rd  = r_q.rd;
    assign tx_line = r_q.tx;
endmodule

// File: rtl/uftx_checker.sv
module uftx_checker #(
    parameter int BIT_TICKS = 5,
    parameter int DATA_W    = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] src_data,
    input logic              src_empty,
    input logic              src_rd,
    input logic              tx_line
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int PW = $clog2(FRAME_W);
    localparam int SW = (BIT_TICKS > 1) ? $clog2(BIT_TICKS) : 1;
    localparam logic [PW-1:0] POS_LAST = PW'(FRAME_W - 1);
    localparam logic [SW-1:0] SUB_LAST = SW'(BIT_TICKS - 1);

    logic              cap_q, act;
    logic [PW-1:0]     pos;
    logic [SW-1:0]     sub;
    logic [DATA_W-1:0] held;
    logic              exp_bit, frame_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= 1'b0;
            act   <= 1'b0;
            pos   <= '0;
            sub   <= '0;
            held  <= '0;
        end else begin
            cap_q <= src_rd;
            if (cap_q) begin
                act  <= 1'b1;
                pos  <= '0;
                sub  <= '0;
                held <= src_data;
            end else if (act) begin
                if (sub == SUB_LAST) begin
                    sub <= '0;
                    if (pos == POS_LAST) act <= 1'b0;
                    else pos <= pos + 1'b1;
                end else begin
                    sub <= sub + 1'b1;
                end
            end
        end
    end

    always_comb begin
        if (pos == '0) exp_bit = 1'b0;
        else if (int'(pos) <= DATA_W) exp_bit = held[int'(pos) - 1];
        else if (int'(pos) == DATA_W + 1) exp_bit = ^held;   // R5 parity
        else exp_bit = 1'b1;
    end

    assign frame_last = act && (sub == SUB_LAST) && (pos == POS_LAST);

    assert_strobe_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        src_rd |=> !src_rd);
    assert_strobe_needs_data_R1: assert property (@(posedge clk) disable iff (rst)
        src_rd |-> !$past(src_empty));
    assert_capture_high_R2: assert property (@(posedge clk) disable iff (rst)
        cap_q |-> tx_line);
    assert_start_after_capture_R2: assert property (@(posedge clk) disable iff (rst)
        cap_q |=> !tx_line);
    // covers R3 order, R4 bit length and R5 parity through the shadow counters
    assert_frame_bits_R3: assert property (@(posedge clk) disable iff (rst)
        act |-> (tx_line == exp_bit));
    assert_idle_high_R6: assert property (@(posedge clk) disable iff (rst)
        !act |-> tx_line);
    assert_reset_idle_R7: assert property (@(posedge clk)
        rst |=> (tx_line && !src_rd));
    assert_no_strobe_in_frame_R8: assert property (@(posedge clk) disable iff (rst)
        (act || cap_q) |-> !src_rd);
    assert_back_to_back_R9: assert property (@(posedge clk) disable iff (rst)
        (frame_last && !src_empty) |=> src_rd);
endmodule

bind uart_fetch_tx uftx_checker #(.BIT_TICKS(BIT_TICKS), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .src_data (src_data),
    .src_empty(src_empty),
    .src_rd   (src_rd),
    .tx_line  (tx_line)
);

// File: tb/uart_fetch_tx_tb.sv
`timescale 1ns/1ps
module uart_fetch_tx_tb;
    localparam int BT = 5;
    localparam int DW = 8;
    localparam int FB = DW + 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [DW-1:0] src_data = '0;
    logic src_empty, src_rd, tx_line;

    logic [DW-1:0] q [0:255];
    int wr_p = 0;
    int rd_p = 0;
    int mon_i = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign src_empty = (wr_p == rd_p);

    uart_fetch_tx #(.BIT_TICKS(BT), .DATA_W(DW)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .src_data (src_data),
        .src_empty(src_empty),
        .src_rd   (src_rd),
        .tx_line  (tx_line)
    );

    // upstream queue model: byte appears the cycle after the request
    always @(posedge clk) begin
        if (src_rd) begin
            src_data <= q[rd_p[7:0]];
            rd_p     <= rd_p + 1;
        end
    end

    function automatic logic exp_bit(logic [DW-1:0] b, int idx);
        if (idx == 0) return 1'b0;
        if (idx <= DW) return b[idx-1];
        if (idx == DW + 1) return ^b;
        return 1'b1;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic push(logic [DW-1:0] b);
        @(posedge clk);
        #1;
        q[wr_p[7:0]] = b;
        wr_p++;
    endtask

    task automatic drain();
        while (rd_p != wr_p) @(posedge clk);
        repeat (FB * BT + 10) @(posedge clk);
    endtask

    // line monitor
    initial begin : mon
        bit expect_b2b;
        bit aborted;
        logic [DW-1:0] cur;
        expect_b2b = 1'b0;
        forever begin
            @(negedge clk);
            if (rst) begin
                expect_b2b = 1'b0;
                continue;
            end
            if (expect_b2b) begin
                chk(src_rd == 1'b1, "R9", int'(src_rd), 1);
                expect_b2b = 1'b0;
            end
            if (!src_rd) begin
                chk(tx_line == 1'b1, "R6", int'(tx_line), 1);
                continue;
            end
            chk(mon_i < wr_p, "R1", mon_i, wr_p);
            cur = q[mon_i[7:0]];
            mon_i++;
            aborted = 1'b0;
            @(negedge clk);
            if (rst) continue;
            chk(src_rd == 1'b0, "R1", int'(src_rd), 0);
            chk(tx_line == 1'b1, "R2", int'(tx_line), 1);
            for (int j = 0; j < FB * BT; j++) begin
                @(negedge clk);
                if (rst) begin
                    aborted = 1'b1;
                    break;
                end
                if (j / BT == 0)
                    chk(tx_line == exp_bit(cur, 0), "R2", int'(tx_line), int'(exp_bit(cur, 0)));
                else if (j / BT == DW + 1)
                    chk(tx_line == exp_bit(cur, j / BT), "R5", int'(tx_line), int'(exp_bit(cur, j / BT)));
                else if (j % BT == 0)
                    chk(tx_line == exp_bit(cur, j / BT), "R3", int'(tx_line), int'(exp_bit(cur, j / BT)));
                else
                    chk(tx_line == exp_bit(cur, j / BT), "R4", int'(tx_line), int'(exp_bit(cur, j / BT)));
                chk(src_rd == 1'b0, "R8", int'(src_rd), 0);
            end
            if (!aborted) expect_b2b = (wr_p > rd_p);
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        #1;
        chk(tx_line == 1'b1 && src_rd == 1'b0, "R6", int'({tx_line, src_rd}), 2);
        rst = 1'b0;

        // directed patterns, isolated then in a burst
        push(8'h00);
        drain();
        push(8'hFF);
        drain();
        push(8'h01);
        push(8'h80);
        push(8'hA5);
        push(8'h5A);
        drain();

        // reset deep inside a character
        push(8'h3C);
        while (!src_rd) @(posedge clk);
        repeat (20) @(posedge clk);
        #1;
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk(tx_line == 1'b1 && src_rd == 1'b0, "R7", int'({tx_line, src_rd}), 2);
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        push(8'hC3);
        drain();

        // random bytes with random gaps and bursts
        for (int n = 0; n < 40; n++) begin
            push(8'($urandom));
            if ($urandom % 3 == 0) repeat ($urandom % 80) @(posedge clk);
        end
        drain();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            summary();
        end
    end
endmodule